// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block makes an external serial flash look like a read-only memory. A requester presents a byte address inside a 256 MB window on a simple valid/ready port. The sequencer rounds the address down to a 32-bit word boundary and builds a left-aligned serial frame for a separate shift engine. The frame holds an 8-bit read opcode, then one to four address bytes, then 32 zero bits that clock the data in. The engine returns the 32 bits it captured, first bit in the most significant position. The sequencer rearranges them from the flash's little-endian storage order into a word and returns it with an error bit.

Two configuration inputs gate the service: a module enable and a transparent-mode enable. The sequencer answers a request with an error and without touching the flash when either enable is low, or when the request is a write. It keeps only one request in flight and shows a busy flag while a flash access runs. If the module enable drops during an access, the sequencer tells the engine to abandon the frame and answers with an error.

Top module: `flash_rd_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. After a request is accepted, no other request is accepted until its response has been given.
- R2: For an access that goes to the flash, the sequencer pulses `phy_start` for one cycle, one cycle after acceptance. `phy_frame[71:64]` holds `cfg_rd_cmd`. The address bytes follow most significant byte first, and every bit below them is 0. `phy_nbits` equals 48 + 8*`cfg_abytes`.
- R3: `cfg_abytes` holds the address byte count minus one (0 gives 1 byte, 3 gives 4 bytes). The bytes sent are the low-order bytes of the 32-bit word address.
- R4: The word address is `{4'b0, req_addr[27:2], 2'b00}`. Address bits 1:0 are never sent, and with four address bytes the top 4 address bits are 0.
- R5: Let the engine return `phy_rdata` = {B0,B1,B2,B3}, where B0 is the first byte received. The response data is {B3,B2,B1,B0}, so B0 lands in bits 7:0.
- R6: An accepted write gets an error response in the following cycle, with data 0, and no `phy_start`.
- R7: An accepted read while `cfg_enable` or `cfg_xmode` is 0 gets an error response in the following cycle, with data 0, and no `phy_start`.
- R8: `busy` is 1 from the cycle after a flash access is accepted until its response cycle. It is 0 otherwise.
- R9: If `cfg_enable` is 0 while `busy` is 1, `phy_abort` is 1 in that cycle. In the next cycle the sequencer gives an error response with data 0.
- R10: `rsp_valid` is a single-cycle pulse, one for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Module enable |
| cfg_xmode | input | 1 | Transparent-mode enable |
| cfg_rd_cmd | input | 8 | Flash read opcode |
| cfg_abytes | input | 2 | Address byte count minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | 28 | Byte address inside the window |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response carries a bus error |
| rsp_data | output | 32 | Response word |
| busy | output | 1 | Flash access in progress |
| phy_start | output | 1 | Launch frame on the shift engine |
| phy_frame | output | 72 | Left-aligned frame to shift out |
| phy_nbits | output | 7 | Frame length in bits |
| phy_abort | output | 1 | Abandon the running frame |
| phy_done | input | 1 | Shift engine finished |
| phy_rdata | input | 32 | Last 32 bits captured, first bit at bit 31 |

## Verification
The bench runs every address width against addresses with nonzero low bits and set high bits. A design that masked the wrong address bits, or packed the bytes on the wrong side of the frame, would show a frame mismatch in the engine model. It returns byte patterns that differ in every lane, so a missing or reversed byte swap shows up as wrong response data. The error paths are checked by counting `phy_start` pulses: a design that still launched a frame on a write or a disabled read would raise that count. The bench also drops the enable while the engine is stalled. A design that waited for the engine would hang, and one that forgot the error bit would return stale data.

// File: rtl/flash_rd_seq.sv
module flash_rd_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_enable,
  input  logic        cfg_xmode,
  input  logic [7:0]  cfg_rd_cmd,
  input  logic [1:0]  cfg_abytes,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [27:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_data,
  output logic        busy,
  output logic        phy_start,
  output logic [71:0] phy_frame,
  output logic [6:0]  phy_nbits,
  output logic        phy_abort,
  input  logic        phy_done,
  input  logic [31:0] phy_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_RESP} state_t;
  state_t state;

  logic [31:0] waddr;
  logic [39:0] head;
  logic        accept, legal;

  assign waddr  = {4'b0000, req_addr[27:2], 2'b00};
  assign accept = req_valid & req_ready;
  assign legal  = cfg_enable & cfg_xmode & ~req_write;

  always_comb begin
    case (cfg_abytes)
      2'd0:    head = {cfg_rd_cmd, waddr[7:0], 24'h0};
      2'd1:    head = {cfg_rd_cmd, waddr[15:0], 16'h0};
      2'd2:    head = {cfg_rd_cmd, waddr[23:0], 8'h0};
      default: head = {cfg_rd_cmd, waddr};
    endcase
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign busy      = (state == S_LAUNCH) | (state == S_WAIT);
  assign phy_start = (state == S_LAUNCH);
  assign phy_abort = busy & ~cfg_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phy_frame <= '0;
      phy_nbits <= '0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          if (legal) begin
            phy_frame <= {head, 32'h0};
            phy_nbits <= 7'd48 + {2'b00, cfg_abytes, 3'b000};
            state     <= S_LAUNCH;
          end else begin
            rsp_err  <= 1'b1;
            rsp_data <= '0;
            state    <= S_RESP;
          end
        end
        S_LAUNCH, S_WAIT: begin
          if (!cfg_enable) begin
            rsp_err  <= 1'b1;
            rsp_data <= '0;
            state    <= S_RESP;
          end else if (state == S_WAIT && phy_done) begin
            rsp_err  <= 1'b0;
            rsp_data <= {phy_rdata[7:0], phy_rdata[15:8], phy_rdata[23:16], phy_rdata[31:24]};
            state    <= S_RESP;
          end else begin
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_rd_seq_chk.sv
module flash_rd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_enable,
  input logic        cfg_xmode,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_data,
  input logic        busy,
  input logic        phy_start,
  input logic [6:0]  phy_nbits,
  input logic        phy_abort
);
  a_r1_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || rsp_valid) |-> !req_ready);

  a_r2_launch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && cfg_enable && cfg_xmode) |=> (phy_start && busy));

  a_r2_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |-> (phy_nbits >= 7'd48 && phy_nbits <= 7'd72 && phy_nbits[2:0] == 3'd0));

  a_r6_write_error: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_valid && rsp_err && rsp_data == 32'h0 && !phy_start));

  a_r7_gate_error: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(cfg_enable && cfg_xmode)) |=> (rsp_valid && rsp_err && !phy_start));

  a_r9_abort_error: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_enable) |-> phy_abort);

  a_r9_abort_response: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_enable) |=> (rsp_valid && rsp_err && !busy));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rsp_valid));
endmodule

bind flash_rd_seq flash_rd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_xmode(cfg_xmode),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .busy(busy), .phy_start(phy_start), .phy_nbits(phy_nbits), .phy_abort(phy_abort)
);

// File: tb/flash_rd_seq_tb.sv
module flash_rd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_xmode = 1'b0;
  logic [7:0]  cfg_rd_cmd = 8'h03;
  logic [1:0]  cfg_abytes = 2'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_err, busy, phy_start, phy_abort;
  logic [31:0] rsp_data;
  logic [71:0] phy_frame;
  logic [6:0]  phy_nbits;
  logic        phy_done = 1'b0;
  logic [31:0] phy_rdata = '0;

  int tests = 0, fails = 0, starts = 0;
  int phy_delay = 6;
  logic [31:0] phy_rx = '0;
  logic [32:0] rsp_q[$];
  logic [78:0] frm_q[$];

  always #5 clk = ~clk;

  flash_rd_seq u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model: checks frames, answers after phy_delay cycles
  initial begin
    int cnt;
    bit pend;
    pend = 0; cnt = 0;
    forever begin
      @(negedge clk);
      phy_done = 1'b0;
      if (phy_start) begin
        logic [78:0] e;
        starts++;
        e = (frm_q.size() > 0) ? frm_q.pop_front() : 79'h0;
        check({phy_nbits, phy_frame} == e, "R2/R3/R4 frame", {1'b0, phy_nbits, phy_frame}, {1'b0, e});
        pend = 1; cnt = phy_delay;
      end else if (pend) begin
        if (!busy) pend = 0;
        else if (--cnt <= 0) begin
          phy_rdata = phy_rx;
          phy_done  = 1'b1;
          pend = 0;
        end
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [32:0] e;
      e = (rsp_q.size() > 0) ? rsp_q.pop_front() : 33'h1_DEADBEEF;
      check({rsp_err, rsp_data} == e, "R5/R6/R7/R9 response", {47'h0, rsp_err, rsp_data}, {47'h0, e});
    end
  end

  function automatic logic [31:0] le_word(input logic [31:0] rx);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = rx[31-8*i -: 8];
    return w;
  endfunction

  task automatic access(input bit wr, input logic [27:0] a, input logic [31:0] rx);
    bit err;
    int s0;
    logic [31:0] wa;
    logic [39:0] head;
    err = wr || !cfg_enable || !cfg_xmode;
    s0 = starts;
    phy_rx = rx;
    if (err) rsp_q.push_back({1'b1, 32'h0});
    else begin
      wa = {4'b0, a[27:2], 2'b00};
      head = {cfg_rd_cmd, wa << (8 * (3 - cfg_abytes))};
      frm_q.push_back({7'd48 + 7'(8 * cfg_abytes), head, 32'h0});
      rsp_q.push_back({1'b0, le_word(rx)});
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!err) begin
      check(busy == 1'b1, "R8 busy during access", {79'h0, busy}, 80'h1);
      check(req_ready == 1'b0, "R1 no accept while busy", {79'h0, req_ready}, 80'h0);
    end
    for (int i = 0; i < 500 && rsp_q.size() > 0; i++) @(negedge clk);
    check(rsp_q.size() == 0, "R10 response given", rsp_q.size(), 0);
    if (err) check(starts == s0, "R6/R7 no frame launched", starts, s0);
    @(negedge clk);
    check(busy == 1'b0 && req_ready == 1'b1, "R8 idle after response", {78'h0, busy, req_ready}, 80'h1);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !busy && !phy_start, "R1 reset state",
          {76'h0, req_ready, rsp_valid, busy, phy_start}, 80'h8);

    // gated off: R7
    access(1'b0, 28'h0000100, 32'h11223344);
    cfg_enable = 1'b1;
    access(1'b0, 28'h0000104, 32'h11223344);
    cfg_xmode = 1'b1;

    // R3 each address width, R4 unaligned + high bits, R5 byte swap
    for (int n = 0; n < 4; n++) begin
      cfg_abytes = 2'(n);
      cfg_rd_cmd = (n == 3) ? 8'h13 : 8'h03;
      access(1'b0, 28'hFEDCBA7, 32'h01234567 + 32'(n) * 32'h11111111);
    end
    cfg_abytes = 2'd2;
    access(1'b0, 28'h0000003, 32'hA5C3_0FF0);
    cfg_rd_cmd = 8'h0B;
    phy_delay = 20;
    access(1'b0, 28'hABCDEF4, 32'h8001_7FFE);

    // writes: R6
    access(1'b1, 28'h0000040, 32'h0);
    cfg_xmode = 1'b0;
    access(1'b1, 28'h0000044, 32'h0);
    cfg_xmode = 1'b1;

    // R9 abort while engine stalled
    phy_delay = 1000;
    rsp_q.push_back({1'b1, 32'h0});
    frm_q.push_back({7'd64, 8'h0B, 24'h000010, 8'h0, 32'h0});
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 28'h0000010;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R9 stalled access busy", {79'h0, busy}, 80'h1);
    cfg_enable = 1'b0;
    #1;
    check(phy_abort == 1'b1, "R9 abort flag", {79'h0, phy_abort}, 80'h1);
    @(negedge clk);
    for (int i = 0; i < 10 && rsp_q.size() > 0; i++) @(negedge clk);
    check(rsp_q.size() == 0, "R9 error response after abort", rsp_q.size(), 0);
    check(busy == 1'b0, "R9 busy cleared", {79'h0, busy}, 80'h0);

    // recovery
    cfg_enable = 1'b1;
    phy_delay = 3;
    access(1'b0, 28'h0000020, 32'hDEAD_BEEF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule